// File: doc/BRIEF.md
# Multi-Way Jump Microsequencer

This block produces the next control-store address of a microprogrammed engine. Each microinstruction carries a sequencing operation. The operation may step to the next address, take a branch to a literal when a condition holds, dispatch through a jump lookup table, call a subroutine or return from one. The condition bit and a 5-bit dispatch selector are captured at the end of each step. The branch and dispatch operations of the following step consume them, so the design has one pipeline stage between testing a value and acting on it.

A dispatch reads the jump table at a page chosen by the microinstruction and an index taken from the captured selector. The table result replaces the low 8 bits of the current address, so the target stays inside the current 256-word page. The index can be used whole (32 ways) or with its top bit forced low or high (two 16-way tables in one page). It can also be forced to zero, which gives a plain jump: entry 0 of every page reads back as that page's own number. The sequencer advances once every `TICKS` clocks, which defaults to 2. It owns a last-in first-out return-address stack of 33 entries.

Top module: `mwj_seq`

## Requirements
- R1: While reset is held, and after its release until the first step, `uaddr_o` is 0 and `stk_err_o` is 0.
- R2: `step_o` is high on one clock in every `TICKS` (default 2), and the first such clock is the second clock after reset release. The address, the latches and the stack change only on a clock edge where `step_o` is high.
- R3: Operation code 0 (increment) loads `uaddr_o + 1`. Codes 5 to 7 behave the same way.
- R4: Operation code 1 (conditional branch) loads `lit_i` if the captured condition bit is 1, and otherwise loads `uaddr_o + 1`. The captured bit is `cc_vec_i[cc_sel_i]` as sampled at the previous step, whatever the current instruction presents.
- R5: Operation code 2 (dispatch) loads `{uaddr_o[15:8], T}`, where T is jump table entry `{jpage_i, idx}`. With mode 0 (full), idx is the 5-bit selector captured at the previous step.
- R6: The selector captured at each step depends on `jsrc_i`: 0 takes `jconst_i`, 1 takes `gtag_i`, 2 takes `gflag_i`, 3 takes `memtag_i`.
- R7: Dispatch mode 2 uses idx = {0, selector[3:0]}. Dispatch mode 3 uses idx = {1, selector[3:0]}.
- R8: Dispatch mode 1 uses idx = 0. Entry 0 of each page always reads as the page number, zero-extended to 8 bits, and writes to any entry 0 have no effect.
- R9: Operation code 3 (call) pushes `uaddr_o + 1` and loads `lit_i`. Operation code 4 (return) loads the most recently pushed address and removes it. The stack holds 33 addresses.
- R10: A call with 33 entries held still loads `lit_i`, but it leaves the stack unchanged and sets `stk_err_o`. A return with an empty stack loads `uaddr_o + 1` and sets `stk_err_o`. `stk_err_o` stays set until reset.
- R11: A jump table write with `jw_en_i` high stores `jw_data_i` at `jw_addr_i` = {page, index} on any clock edge, including while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Sequencing operation of the current microinstruction |
| lit_i | input | 16 | Literal target address |
| cc_sel_i | input | 5 | Condition select for the capture at this step |
| cc_vec_i | input | 32 | Candidate condition bits |
| jsrc_i | input | 2 | Selector source for the capture at this step |
| jconst_i | input | 5 | Constant selector from the microinstruction |
| gtag_i | input | 5 | Tag field of the data register |
| gflag_i | input | 5 | Pointer flags field of the data register |
| memtag_i | input | 5 | Top tag bits of the memory output |
| jmode_i | input | 2 | Dispatch mode: 0 full, 1 zero, 2 low half, 3 high half |
| jpage_i | input | 3 | Jump table page for a dispatch |
| jw_en_i | input | 1 | Jump table write enable |
| jw_addr_i | input | 8 | Jump table write address {page, index} |
| jw_data_i | input | 8 | Jump table write data |
| uaddr_o | output | 16 | Current microaddress |
| step_o | output | 1 | High on the clock whose edge advances the sequencer |
| stk_err_o | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The checker assumes that the microinstruction fields stay steady for the whole step, from just after one advancing edge to the next. The bench changes them only when it stands one time unit after an advancing edge, and then waits for `step_o` before it lets the edge come. The checker also assumes that the jump table entries it dispatches through were written before use. The bench loads every page while reset is held and checks no table value that it did not write itself.

// File: rtl/mwj_pkg.sv
package mwj_pkg;
  localparam int SEL_W = 5;

  typedef enum logic [2:0] {
    OP_INC  = 3'd0,
    OP_BRC  = 3'd1,
    OP_MWJ  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    JM_FULL = 2'd0,
    JM_ZERO = 2'd1,
    JM_LO16 = 2'd2,
    JM_HI16 = 2'd3
  } jmode_e;
endpackage

// File: rtl/mwj_sel_latch.sv
module mwj_sel_latch #(
  parameter int CC_N  = 32,
  parameter int SEL_W = 5,
  localparam int CCS_W = $clog2(CC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CC_N-1:0]  cc_vec,
  input  logic [CCS_W-1:0] cc_sel,
  input  logic [1:0]       jsrc,
  input  logic [SEL_W-1:0] jconst,
  input  logic [SEL_W-1:0] gtag,
  input  logic [SEL_W-1:0] gflag,
  input  logic [SEL_W-1:0] memtag,
  output logic             cc_q,
  output logic [SEL_W-1:0] j_q
);
  logic [SEL_W-1:0] src [4];

  assign src[0] = jconst;
  assign src[1] = gtag;
  assign src[2] = gflag;
  assign src[3] = memtag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_q <= 1'b0;
      j_q  <= '0;
    end else if (load) begin
      cc_q <= cc_vec[cc_sel];
      j_q  <= src[jsrc];
    end
  end
endmodule

// File: rtl/mwj_jram.sv
module mwj_jram #(
  parameter int PAGE_W = 3,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 8,
  localparam int AW      = PAGE_W + IDX_W,
  localparam int ENTRIES = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PAGE_W-1:0] rpage,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we && (waddr[IDX_W-1:0] != '0)) mem[waddr] <= wdata;
  end

  always_comb begin
    if (ridx == '0) rdata = DATA_W'(rpage);
    else            rdata = mem[{rpage, ridx}];
  end
endmodule

// File: rtl/mwj_stack.sv
module mwj_stack #(
  parameter int DEPTH = 33,
  parameter int W     = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     top,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] cnt
);
  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] top_idx;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign top_idx = cnt - CNT_W'(1);
  assign top     = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push && !full) begin
      mem[cnt] <= din;
      cnt      <= cnt + CNT_W'(1);
    end else if (pop && !empty) begin
      cnt <= top_idx;
    end
  end
endmodule

// File: rtl/mwj_seq.sv
module mwj_seq #(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 8,
  parameter int CC_N    = 32,
  parameter int JPAGE_W = 3,
  parameter int DEPTH   = 33,
  parameter int TICKS   = 2,
  localparam int SEL_W  = mwj_pkg::SEL_W,
  localparam int CCS_W  = $clog2(CC_N),
  localparam int JA_W   = JPAGE_W + SEL_W,
  localparam int PH_W   = (TICKS > 1) ? $clog2(TICKS) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         op_i,
  input  logic [ADDR_W-1:0]  lit_i,
  input  logic [CCS_W-1:0]   cc_sel_i,
  input  logic [CC_N-1:0]    cc_vec_i,
  input  logic [1:0]         jsrc_i,
  input  logic [SEL_W-1:0]   jconst_i,
  input  logic [SEL_W-1:0]   gtag_i,
  input  logic [SEL_W-1:0]   gflag_i,
  input  logic [SEL_W-1:0]   memtag_i,
  input  logic [1:0]         jmode_i,
  input  logic [JPAGE_W-1:0] jpage_i,
  input  logic               jw_en_i,
  input  logic [JA_W-1:0]    jw_addr_i,
  input  logic [OFF_W-1:0]   jw_data_i,
  output logic [ADDR_W-1:0]  uaddr_o,
  output logic               step_o,
  output logic               stk_err_o
);
  import mwj_pkg::*;

  logic [PH_W-1:0]   phase;
  logic              cc_q;
  logic [SEL_W-1:0]  j_q;
  logic [SEL_W-1:0]  jidx;
  logic [OFF_W-1:0]  jr_data;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] stk_top;
  logic              stk_full;
  logic              stk_empty;
  logic [CNT_W-1:0]  sp;
  logic              push;
  logic              pop;
  logic              err_set;

  assign seq_addr = uaddr_o + ADDR_W'(1);

  generate
    if (TICKS > 1) begin : g_div
      assign step_o = (phase == PH_W'(TICKS - 1));
      always_ff @(posedge clk) begin
        if (!rst_n)      phase <= '0;
        else if (step_o) phase <= '0;
        else             phase <= phase + PH_W'(1);
      end
    end else begin : g_nodiv
      assign step_o = 1'b1;
      always_ff @(posedge clk) phase <= '0;
    end
  endgenerate

  mwj_sel_latch #(.CC_N(CC_N), .SEL_W(SEL_W)) latch_i (
    .clk(clk), .rst_n(rst_n), .load(step_o),
    .cc_vec(cc_vec_i), .cc_sel(cc_sel_i), .jsrc(jsrc_i),
    .jconst(jconst_i), .gtag(gtag_i), .gflag(gflag_i), .memtag(memtag_i),
    .cc_q(cc_q), .j_q(j_q)
  );

  always_comb begin
    case (jmode_i)
      JM_ZERO: jidx = '0;
      JM_LO16: jidx = {1'b0, j_q[SEL_W-2:0]};
      JM_HI16: jidx = {1'b1, j_q[SEL_W-2:0]};
      default: jidx = j_q;
    endcase
  end

  mwj_jram #(.PAGE_W(JPAGE_W), .IDX_W(SEL_W), .DATA_W(OFF_W)) jram_i (
    .clk(clk), .we(jw_en_i), .waddr(jw_addr_i), .wdata(jw_data_i),
    .rpage(jpage_i), .ridx(jidx), .rdata(jr_data)
  );

  mwj_stack #(.DEPTH(DEPTH), .W(ADDR_W)) stack_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(seq_addr),
    .top(stk_top), .full(stk_full), .empty(stk_empty), .cnt(sp)
  );

  always_comb begin
    nxt     = seq_addr;
    push    = 1'b0;
    pop     = 1'b0;
    err_set = 1'b0;
    case (op_i)
      OP_BRC:  if (cc_q) nxt = lit_i;
      OP_MWJ:  nxt = {uaddr_o[ADDR_W-1:OFF_W], jr_data};
      OP_CALL: begin
        nxt = lit_i;
        if (stk_full) err_set = step_o;
        else          push    = step_o;
      end
      OP_RET: begin
        if (stk_empty) err_set = step_o;
        else begin
          pop = step_o;
          nxt = stk_top;
        end
      end
      default: nxt = seq_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uaddr_o   <= '0;
      stk_err_o <= 1'b0;
    end else if (step_o) begin
      uaddr_o <= nxt;
      if (err_set) stk_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mwj_seq_chk.sv
module mwj_seq_chk #(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 8,
  parameter int JPAGE_W = 3,
  parameter int DEPTH   = 33,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               step_o,
  input logic [2:0]         op_i,
  input logic [ADDR_W-1:0]  lit_i,
  input logic [1:0]         jmode_i,
  input logic [JPAGE_W-1:0] jpage_i,
  input logic [ADDR_W-1:0]  uaddr_o,
  input logic               stk_err_o,
  input logic               cc_q,
  input logic [CNT_W-1:0]   sp
);
  AST_HOLD_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !step_o |=> $stable(uaddr_o)); // R2

  AST_INC_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && op_i == 3'd0) |=> uaddr_o == $past(uaddr_o) + ADDR_W'(1)); // R3

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && op_i == 3'd1) |=>
      uaddr_o == ($past(cc_q) ? $past(lit_i) : $past(uaddr_o) + ADDR_W'(1))); // R4

  AST_DISPATCH_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && op_i == 3'd2) |=>
      uaddr_o[ADDR_W-1:OFF_W] == $past(uaddr_o[ADDR_W-1:OFF_W])); // R5

  AST_ZERO_INDEX_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && op_i == 3'd2 && jmode_i == 2'd1) |=>
      uaddr_o[OFF_W-1:0] == OFF_W'($past(jpage_i))); // R8

  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && op_i == 3'd3) |=> uaddr_o == $past(lit_i)); // R9

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= CNT_W'(DEPTH)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err_o |=> stk_err_o); // R10
endmodule

bind mwj_seq mwj_seq_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .JPAGE_W(JPAGE_W), .DEPTH(DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .step_o(step_o), .op_i(op_i), .lit_i(lit_i),
  .jmode_i(jmode_i), .jpage_i(jpage_i), .uaddr_o(uaddr_o),
  .stk_err_o(stk_err_o), .cc_q(cc_q), .sp(sp)
);

// File: tb/mwj_seq_tb_top.sv
module mwj_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [15:0] lit_i;
  logic [4:0]  cc_sel_i;
  logic [31:0] cc_vec_i;
  logic [1:0]  jsrc_i;
  logic [4:0]  jconst_i, gtag_i, gflag_i, memtag_i;
  logic [1:0]  jmode_i;
  logic [2:0]  jpage_i;
  logic        jw_en_i;
  logic [7:0]  jw_addr_i;
  logic [7:0]  jw_data_i;
  logic [15:0] uaddr_o;
  logic        step_o;
  logic        stk_err_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] exp_a;

  always #5 clk = ~clk;

  mwj_seq dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .lit_i(lit_i), .cc_sel_i(cc_sel_i),
    .cc_vec_i(cc_vec_i), .jsrc_i(jsrc_i), .jconst_i(jconst_i), .gtag_i(gtag_i),
    .gflag_i(gflag_i), .memtag_i(memtag_i), .jmode_i(jmode_i), .jpage_i(jpage_i),
    .jw_en_i(jw_en_i), .jw_addr_i(jw_addr_i), .jw_data_i(jw_data_i),
    .uaddr_o(uaddr_o), .step_o(step_o), .stk_err_o(stk_err_o)
  );

  function automatic logic [7:0] jfn(input int p, input int i);
    return 8'((p * 37 + i * 11 + 1) & 255);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic advance();
    @(negedge clk);
    while (!step_o) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] lit,
                       input logic [1:0] jm, input logic [2:0] pg);
    op_i = op; lit_i = lit; jmode_i = jm; jpage_i = pg;
    advance();
  endtask

  task automatic jwrite(input int p, input int i, input logic [7:0] d);
    @(negedge clk);
    jw_en_i = 1'b1; jw_addr_i = 8'((p << 5) | i); jw_data_i = d;
    @(posedge clk);
    #1 jw_en_i = 1'b0;
  endtask

  task automatic do_reset(input bit load);
    rst_n = 1'b0;
    op_i = 3'd0; lit_i = '0; cc_sel_i = '0; cc_vec_i = '0; jsrc_i = '0;
    jconst_i = '0; gtag_i = '0; gflag_i = '0; memtag_i = '0;
    jmode_i = '0; jpage_i = '0; jw_en_i = 1'b0; jw_addr_i = '0; jw_data_i = '0;
    repeat (2) @(posedge clk);
    if (load) begin
      for (int p = 0; p < 8; p++)
        for (int i = 1; i < 32; i++) jwrite(p, i, jfn(p, i)); // R11 writes under reset
      jwrite(2, 0, 8'hAA); // R8 write to entry 0, must be ignored
    end
    @(posedge clk);
    #1 rst_n = 1'b1;
    exp_a = 16'h0000;
  endtask

  task automatic t_reset();
    chk("R1 uaddr in reset", uaddr_o, 16'h0000);
    chk("R1 err in reset", {15'd0, stk_err_o}, 16'h0000);
    @(posedge clk); #1;
    chk("R2 no step on first clock", uaddr_o, 16'h0000);
  endtask

  task automatic t_inc();
    for (int k = 0; k < 3; k++) begin
      issue(3'd0, 16'hFFFF, 2'd0, 3'd0);
      exp_a = exp_a + 16'd1;
      chk("R3 increment", uaddr_o, exp_a);
    end
    op_i = 3'd5;
    advance();
    exp_a = exp_a + 16'd1;
    chk("R3 spare code increments", uaddr_o, exp_a);
    @(posedge clk); #1;
    chk("R2 hold between steps", uaddr_o, exp_a);
  endtask

  task automatic t_branch();
    cc_sel_i = 5'd5; cc_vec_i = 32'h0000_0020;
    issue(3'd0, 16'h0000, 2'd0, 3'd0);
    exp_a = exp_a + 16'd1;
    cc_vec_i = 32'hFFFF_FFDF;
    issue(3'd1, 16'h1234, 2'd0, 3'd0);
    chk("R4 branch taken on prior bit", uaddr_o, 16'h1234);
    exp_a = 16'h1234;
    cc_vec_i = 32'hFFFF_FFFF;
    issue(3'd1, 16'h2000, 2'd0, 3'd0);
    exp_a = exp_a + 16'd1;
    chk("R4 branch not taken on prior bit", uaddr_o, exp_a);
    cc_vec_i = '0;
  endtask

  task automatic t_dispatch(input string tag, input logic [1:0] src,
                            input logic [4:0] v, input logic [1:0] jm,
                            input logic [2:0] pg, input logic [7:0] expl);
    jsrc_i = src;
    jconst_i = 5'd3; gtag_i = 5'd9; gflag_i = 5'd12; memtag_i = 5'd30;
    case (src)
      2'd0: jconst_i = v;
      2'd1: gtag_i = v;
      2'd2: gflag_i = v;
      default: memtag_i = v;
    endcase
    issue(3'd0, 16'h0000, 2'd0, 3'd0);
    exp_a = exp_a + 16'd1;
    jsrc_i = 2'd0; jconst_i = 5'd0;
    issue(3'd2, 16'h0000, jm, pg);
    exp_a = {exp_a[15:8], expl};
    chk(tag, uaddr_o, exp_a);
  endtask

  task automatic t_calls();
    logic [15:0] r1, r2;
    r1 = exp_a + 16'd1;
    issue(3'd3, 16'h0300, 2'd0, 3'd0);
    chk("R9 call target", uaddr_o, 16'h0300);
    r2 = 16'h0301;
    issue(3'd3, 16'h0400, 2'd0, 3'd0);
    chk("R9 nested call target", uaddr_o, 16'h0400);
    issue(3'd4, 16'h0000, 2'd0, 3'd0);
    chk("R9 return inner", uaddr_o, r2);
    issue(3'd4, 16'h0000, 2'd0, 3'd0);
    chk("R9 return outer", uaddr_o, r1);
    chk("R9 no error", {15'd0, stk_err_o}, 16'h0000);
    exp_a = r1;
  endtask

  task automatic t_underflow();
    do_reset(1'b0);
    issue(3'd4, 16'h0777, 2'd0, 3'd0);
    chk("R10 empty return increments", uaddr_o, 16'h0001);
    chk("R10 empty return sets error", {15'd0, stk_err_o}, 16'h0001);
    issue(3'd0, 16'h0000, 2'd0, 3'd0);
    chk("R10 error sticky", {15'd0, stk_err_o}, 16'h0001);
  endtask

  task automatic t_overflow();
    logic [15:0] last_push, lit;
    do_reset(1'b0);
    chk("R1 error cleared by reset", {15'd0, stk_err_o}, 16'h0000);
    last_push = 16'h0000;
    for (int k = 0; k < 33; k++) begin
      lit = 16'(16'h0100 + k * 2);
      last_push = exp_a + 16'd1;
      issue(3'd3, lit, 2'd0, 3'd0);
      exp_a = lit;
    end
    chk("R9 33 calls no error", {15'd0, stk_err_o}, 16'h0000);
    chk("R9 33rd call target", uaddr_o, exp_a);
    issue(3'd3, 16'h0A00, 2'd0, 3'd0);
    chk("R10 full call still jumps", uaddr_o, 16'h0A00);
    chk("R10 full call sets error", {15'd0, stk_err_o}, 16'h0001);
    issue(3'd4, 16'h0000, 2'd0, 3'd0);
    chk("R10 stack unchanged by refused push", uaddr_o, last_push);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    t_reset();
    t_inc();
    t_branch();
    t_dispatch("R5 full 32-way const", 2'd0, 5'd7,  2'd0, 3'd3, jfn(3, 7));
    t_dispatch("R6 source gtag",       2'd1, 5'd25, 2'd0, 3'd1, jfn(1, 25));
    t_dispatch("R6 source gflag",      2'd2, 5'd10, 2'd0, 3'd4, jfn(4, 10));
    t_dispatch("R6 source memtag",     2'd3, 5'd19, 2'd0, 3'd7, jfn(7, 19));
    t_dispatch("R7 low half forced",   2'd0, 5'h16, 2'd2, 3'd6, jfn(6, 6));
    t_dispatch("R7 high half forced",  2'd0, 5'h06, 2'd3, 3'd6, jfn(6, 22));
    t_dispatch("R8 zero index page5",  2'd0, 5'h1F, 2'd1, 3'd5, 8'd5);
    t_dispatch("R8 entry0 write ignored", 2'd0, 5'h1F, 2'd1, 3'd2, 8'd2);
    t_dispatch("R11 write under reset kept", 2'd1, 5'd1, 2'd0, 3'd0, jfn(0, 1));
    t_calls();
    t_underflow();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule